// File: doc/BRIEF.md
# Two-Phase Branch Direction and Target Predictor

This block makes two predictions for every branch. Early in the pipeline, a small set-associative target cache is looked up with the current fetch address. A hit means the branch is guessed taken, and the stored target becomes the next fetch address. A miss means the fetch path falls through. Later, when the branch reaches dispatch, a larger direct-mapped table of two-bit saturating counters makes the final direction decision. Branches whose outcome is already known at dispatch bypass the table. Those are unconditional branches, and conditional branches whose condition bits are ready. Whenever the dispatch decision differs from the early guess, the block raises a one-cycle redirect so that fetch follows the dispatch direction.

Resolved outcomes come back through an update port. For conditional branches, the outcome trains the counter that the branch address selects. The new counter value then decides whether a PC-relative branch is written into the target cache or removed from it. Unconditional PC-relative branches are always written in. Branches whose target comes from a register are never cached, because their targets change from one execution to the next.

Both lookups are combinational. All updates take effect at the next rising clock edge, so a lookup in the same cycle as an update still sees the old state.

Top module: `twophase_bpred`

## Requirements
- R1: After reset, no fetch address hits, and every counter holds the weakly not-taken value 2'b01.
- R2: After an update writes an entry into the target cache, a fetch lookup of that branch address in the next cycle reports a hit and the stored target.
- R3: The target cache has 128 sets of two ways. The set is selected by address bits [8:2] and the tag is bits [31:9].
  - On insertion, a matching way is refreshed in place.
  - If no way matches, an empty way is filled, way 0 first.
  - If both ways are full, the least recently written way is replaced.
- R4: An update whose branch kind has bit 1 set (target taken from a register) never writes the target cache.
- R5: An update whose kind has bit 0 clear (conditional) moves the selected counter up by one on taken and down by one on not-taken, saturating at 0 and 3.
  - For a PC-relative conditional branch (kind 2'b00), a new counter value of 2 or more writes the branch and its target into the target cache.
- R6: A PC-relative conditional update that leaves the counter below 2 removes any matching target-cache entry.
- R7: At dispatch, a branch whose kind has bit 0 set (unconditional) is decided taken.
- R8: At dispatch, a conditional branch flagged as already resolved is decided in its resolved direction.
- R9: At dispatch, an unresolved conditional branch is decided taken exactly when the counter at address bits [12:2] is 2 or 3.
- R10: The redirect output is high exactly when dispatch is valid and the decided direction differs from the fetch-stage hit flag carried with the branch.
- R11: Two branch addresses that differ by a multiple of 2048 instructions (8192 bytes) share one counter.
- R12: An update with an unconditional kind leaves every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_pc | input | ADDR_W | Fetch address being looked up |
| f_hit | output | 1 | Target cache hit (guess taken) |
| f_target | output | ADDR_W | Predicted next fetch address on a hit, zero otherwise |
| d_valid | input | 1 | A branch is at dispatch |
| d_pc | input | ADDR_W | Address of the dispatching branch |
| d_kind | input | 2 | Branch kind: bit 0 = unconditional, bit 1 = register target |
| d_resolved | input | 1 | Condition bits are already available |
| d_resolved_taken | input | 1 | Direction given by the available condition bits |
| d_fetch_hit | input | 1 | Fetch-stage hit flag that travelled with the branch |
| d_taken | output | 1 | Final dispatch direction |
| d_redirect | output | 1 | Dispatch decision overrides the fetch guess |
| u_valid | input | 1 | A resolved outcome is presented |
| u_kind | input | 2 | Kind of the resolved branch, same encoding as d_kind |
| u_pc | input | ADDR_W | Address of the resolved branch |
| u_taken | input | 1 | Actual direction |
| u_target | input | ADDR_W | Actual taken target |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- **Set conflicts.** Three branches share one target-cache set. A wrong replacement choice evicts the most recent branch, or leaves a stale branch that still hits.
- **Counter saturation and training.** Repeated outcomes push counters to their limits and back. A counter that wraps would flip a strongly taken branch to not-taken, and a branch that drops below 2 but stays cached would keep producing false early hits.
- **Register-target branches.** These must never enter the cache.
- **Aliased addresses.** Two addresses 8192 bytes apart must share a counter; a table indexed on the wrong bits would train them separately.
- **Dispatch precedence.** Cases where an unconditional or already-resolved branch disagrees with its counter expose wrong precedence as a false redirect.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  // bit 0: unconditional, bit 1: target comes from a register
  typedef enum logic [1:0] {
    BK_COND_REL   = 2'b00,
    BK_UNCOND_REL = 2'b01,
    BK_COND_REG   = 2'b10,
    BK_UNCOND_REG = 2'b11
  } br_kind_e;

  localparam logic [1:0] CTR_RESET = 2'b01;

  // saturating two-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken) begin
      if (cur != 2'b11) nxt = cur + 2'd1;
    end else begin
      if (cur != 2'b00) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bpred_hist_table.sv
module bpred_hist_table #(
  parameter int ENTRIES = 2048,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic [1:0]       upd_next_ctr
);
  import bpred_pkg::*;

  logic [1:0] ctr_q [ENTRIES];

  // next-state: counter value after the pending outcome
  always_comb begin
    upd_next_ctr = ctr_step(ctr_q[upd_idx], upd_taken);
    rd_ctr       = ctr_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= upd_next_ctr;
    end
  end

endmodule

// File: rtl/bpred_target_cache.sv
module bpred_target_cache #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 128,
  localparam int WAYS  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - 2 - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              wr_en,
  input  logic              wr_insert,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_target
);

  logic [SET_W-1:0] lk_set, wr_set;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic [1:0]       unused_low;

  assign lk_set     = lk_pc[2 +: SET_W];
  assign lk_tag     = lk_pc[ADDR_W-1 -: TAG_W];
  assign wr_set     = wr_pc[2 +: SET_W];
  assign wr_tag     = wr_pc[ADDR_W-1 -: TAG_W];
  assign unused_low = lk_pc[1:0] ^ wr_pc[1:0];

  logic [WAYS-1:0]   lk_match, wr_match, wr_vld_w, way_we;
  logic [ADDR_W-1:0] lk_tgt_w [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic              vld_q [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [ADDR_W-1:0] tgt_q [SETS];

    assign lk_match[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign lk_tgt_w[w] = tgt_q[lk_set];
    assign wr_vld_w[w] = vld_q[wr_set];
    assign wr_match[w] = vld_q[wr_set] && (tag_q[wr_set] == wr_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) vld_q[i] <= 1'b0;
      end else if (way_we[w]) begin
        vld_q[wr_set] <= wr_insert;
      end
    end

    // payload carries no reset; it is only read behind a valid bit
    always_ff @(posedge clk) begin
      if (way_we[w] && wr_insert) begin
        tag_q[wr_set] <= wr_tag;
        tgt_q[wr_set] <= wr_target;
      end
    end
  end

  assign lk_hit    = |lk_match;
  assign lk_target = lk_match[1] ? lk_tgt_w[1] : (lk_match[0] ? lk_tgt_w[0] : '0);

  // replacement state: bit names the way to fill next
  logic lru_q [SETS];
  logic lru_we, lru_d, victim, sel_way, hit_way;

  always_comb begin
    way_we  = '0;
    lru_we  = 1'b0;
    lru_d   = lru_q[wr_set];
    hit_way = wr_match[1];
    if (!wr_vld_w[0])      victim = 1'b0;
    else if (!wr_vld_w[1]) victim = 1'b1;
    else                   victim = lru_q[wr_set];
    sel_way = (|wr_match) ? hit_way : victim;
    if (wr_en) begin
      if (wr_insert) begin
        way_we[sel_way] = 1'b1;
        lru_we          = 1'b1;
        lru_d           = ~sel_way;
      end else if (|wr_match) begin
        way_we[hit_way] = 1'b1;
        lru_we          = 1'b1;
        lru_d           = hit_way;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) lru_q[i] <= 1'b0;
    end else if (lru_we) begin
      lru_q[wr_set] <= lru_d;
    end
  end

endmodule

// File: rtl/bpred_dispatch_decide.sv
module bpred_dispatch_decide (
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       resolved,
  input  logic       resolved_taken,
  input  logic [1:0] ctr,
  input  logic       fetch_hit,
  output logic       taken,
  output logic       redirect
);

  always_comb begin
    if (kind[0])       taken = 1'b1;
    else if (resolved) taken = resolved_taken;
    else               taken = ctr[1];
    redirect = valid && (taken != fetch_hit);
  end

endmodule

// File: rtl/twophase_bpred.sv
module twophase_bpred #(
  parameter int ADDR_W     = 32,
  parameter int TC_SETS    = 128,
  parameter int HT_ENTRIES = 2048,
  localparam int HT_IDX_W  = $clog2(HT_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] f_pc,
  output logic              f_hit,
  output logic [ADDR_W-1:0] f_target,
  input  logic              d_valid,
  input  logic [ADDR_W-1:0] d_pc,
  input  logic [1:0]        d_kind,
  input  logic              d_resolved,
  input  logic              d_resolved_taken,
  input  logic              d_fetch_hit,
  output logic              d_taken,
  output logic              d_redirect,
  input  logic              u_valid,
  input  logic [1:0]        u_kind,
  input  logic [ADDR_W-1:0] u_pc,
  input  logic              u_taken,
  input  logic [ADDR_W-1:0] u_target
);

  logic [1:0] d_ctr, u_next_ctr;
  logic       ht_upd_en, tc_wr_en, tc_wr_insert;
  logic [ADDR_W-HT_IDX_W-1:0] unused_dpc;

  assign unused_dpc = {d_pc[ADDR_W-1:HT_IDX_W+2], d_pc[1:0]};

  // counters train only on conditional outcomes
  assign ht_upd_en    = u_valid && !u_kind[0];
  // register-target branches stay out of the cache
  assign tc_wr_en     = u_valid && !u_kind[1];
  assign tc_wr_insert = u_kind[0] ? 1'b1 : u_next_ctr[1];

  bpred_hist_table #(.ENTRIES(HT_ENTRIES)) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (d_pc[2 +: HT_IDX_W]),
    .rd_ctr       (d_ctr),
    .upd_en       (ht_upd_en),
    .upd_idx      (u_pc[2 +: HT_IDX_W]),
    .upd_taken    (u_taken),
    .upd_next_ctr (u_next_ctr)
  );

  bpred_target_cache #(.ADDR_W(ADDR_W), .SETS(TC_SETS)) u_tcache (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (f_pc),
    .lk_hit    (f_hit),
    .lk_target (f_target),
    .wr_en     (tc_wr_en),
    .wr_insert (tc_wr_insert),
    .wr_pc     (u_pc),
    .wr_target (u_target)
  );

  bpred_dispatch_decide u_decide (
    .valid          (d_valid),
    .kind           (d_kind),
    .resolved       (d_resolved),
    .resolved_taken (d_resolved_taken),
    .ctr            (d_ctr),
    .fetch_hit      (d_fetch_hit),
    .taken          (d_taken),
    .redirect       (d_redirect)
  );

endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] f_pc,
  input logic              f_hit,
  input logic [ADDR_W-1:0] f_target,
  input logic              d_valid,
  input logic [1:0]        d_kind,
  input logic              d_resolved,
  input logic              d_resolved_taken,
  input logic              d_fetch_hit,
  input logic              d_taken,
  input logic              d_redirect,
  input logic              u_valid,
  input logic [1:0]        u_kind,
  input logic [ADDR_W-1:0] u_pc,
  input logic [ADDR_W-1:0] u_target
);

  // R10: idle dispatch never redirects
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !d_valid |-> !d_redirect);

  // R10: redirect follows disagreement with the early guess
  a_r10_redirect_disagree: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> (d_redirect == (d_taken != d_fetch_hit)));

  // R7: unconditional kinds are decided taken
  a_r7_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_kind[0]) |-> d_taken);

  // R8: early-resolved conditional follows its resolution
  a_r8_resolved_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_kind[0] && d_resolved) |-> (d_taken == d_resolved_taken));

  // R2: unconditional PC-relative insert is visible one cycle later
  a_r2_insert_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(u_valid && (u_kind == 2'b01)) && (f_pc == $past(u_pc)))
      |-> (f_hit && (f_target == $past(u_target))));

endmodule

bind twophase_bpred bpred_checker #(.ADDR_W(ADDR_W)) u_bpred_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .f_pc             (f_pc),
  .f_hit            (f_hit),
  .f_target         (f_target),
  .d_valid          (d_valid),
  .d_kind           (d_kind),
  .d_resolved       (d_resolved),
  .d_resolved_taken (d_resolved_taken),
  .d_fetch_hit      (d_fetch_hit),
  .d_taken          (d_taken),
  .d_redirect       (d_redirect),
  .u_valid          (u_valid),
  .u_kind           (u_kind),
  .u_pc             (u_pc),
  .u_target         (u_target)
);

// File: tb/twophase_bpred_bench.sv
module twophase_bpred_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETS = 128;
  localparam int HTE  = 2048;

  logic        clk, rst_n;
  logic [31:0] f_pc, d_pc, u_pc, u_target, f_target;
  logic        f_hit, d_valid, d_resolved, d_resolved_taken, d_fetch_hit;
  logic        d_taken, d_redirect, u_valid, u_taken;
  logic [1:0]  d_kind, u_kind;

  int n_tests, n_fail;

  twophase_bpred u_twophase_bpred (
    .clk(clk), .rst_n(rst_n), .f_pc(f_pc), .f_hit(f_hit), .f_target(f_target),
    .d_valid(d_valid), .d_pc(d_pc), .d_kind(d_kind), .d_resolved(d_resolved),
    .d_resolved_taken(d_resolved_taken), .d_fetch_hit(d_fetch_hit),
    .d_taken(d_taken), .d_redirect(d_redirect), .u_valid(u_valid),
    .u_kind(u_kind), .u_pc(u_pc), .u_taken(u_taken), .u_target(u_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  int          m_ctr [HTE];
  bit          m_v   [SETS][2];
  logic [22:0] m_tag [SETS][2];
  logic [31:0] m_tgt [SETS][2];
  bit          m_lru [SETS];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_hw(input logic [31:0] pc);
    int s = int'(pc[8:2]);
    for (int w = 0; w < 2; w++)
      if (m_v[s][w] && m_tag[s][w] == pc[31:9]) return w;
    return -1;
  endfunction

  task automatic m_update(input logic [1:0] k, input logic [31:0] pc, input bit tk, input logic [31:0] tg);
    int hi = int'(pc[12:2]);
    int s  = int'(pc[8:2]);
    int nc = m_ctr[hi];
    int hw, way;
    bit ins;
    if (!k[0]) begin
      if (tk) nc = (nc == 3) ? 3 : nc + 1;
      else    nc = (nc == 0) ? 0 : nc - 1;
      m_ctr[hi] = nc;
    end
    if (!k[1]) begin
      ins = k[0] ? 1'b1 : (nc >= 2);
      hw  = m_hw(pc);
      if (ins) begin
        if (hw >= 0)         way = hw;
        else if (!m_v[s][0]) way = 0;
        else if (!m_v[s][1]) way = 1;
        else                 way = int'(m_lru[s]);
        m_v[s][way] = 1'b1; m_tag[s][way] = pc[31:9]; m_tgt[s][way] = tg;
        m_lru[s] = (way == 0);
      end else if (hw >= 0) begin
        m_v[s][hw] = 1'b0;
        m_lru[s] = (hw == 1);
      end
    end
  endtask

  // one cycle: drive, check combinational outputs, clock, advance model
  task automatic step(input logic [31:0] fpc,
                      input bit dv, input logic [31:0] dpc, input logic [1:0] dk,
                      input bit dr, input bit drt, input bit dfh,
                      input bit uv, input logic [1:0] uk, input logic [31:0] upc,
                      input bit ut, input logic [31:0] utg);
    int hw;
    bit et;
    @(negedge clk);
    f_pc = fpc; d_valid = dv; d_pc = dpc; d_kind = dk; d_resolved = dr;
    d_resolved_taken = drt; d_fetch_hit = dfh;
    u_valid = uv; u_kind = uk; u_pc = upc; u_taken = ut; u_target = utg;
    #1;
    hw = m_hw(fpc);
    check(f_hit == (hw >= 0), "R2/R3 fetch hit", {31'd0, f_hit}, {31'd0, hw >= 0});
    if (hw >= 0) check(f_target == m_tgt[int'(fpc[8:2])][hw], "R2 fetch target", f_target, m_tgt[int'(fpc[8:2])][hw]);
    if (dk[0])   et = 1'b1;
    else if (dr) et = drt;
    else         et = (m_ctr[int'(dpc[12:2])] >= 2);
    if (dv) begin
      check(d_taken == et, dk[0] ? "R7 uncond dir" : (dr ? "R8 resolved dir" : "R9 counter dir"),
            {31'd0, d_taken}, {31'd0, et});
      check(d_redirect == (et != dfh), "R10 redirect", {31'd0, d_redirect}, {31'd0, et != dfh});
    end else begin
      check(!d_redirect, "R10 idle redirect", {31'd0, d_redirect}, 32'd0);
    end
    @(posedge clk);
    if (uv) m_update(uk, upc, ut, utg);
  endtask

  task automatic upd(input logic [1:0] k, input logic [31:0] pc, input bit tk, input logic [31:0] tg);
    step(32'h0, 1'b0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, k, pc, tk, tg);
  endtask

  task automatic probe_f(input logic [31:0] pc, input bit exp_hit, input string req);
    step(pc, 1'b0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);
    #1;
    check(f_hit == exp_hit, req, {31'd0, f_hit}, {31'd0, exp_hit});
  endtask

  task automatic probe_d(input logic [31:0] pc, input bit exp_tk, input string req);
    step(32'h0, 1'b1, pc, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);
    #1;
    check(d_taken == exp_tk, req, {31'd0, d_taken}, {31'd0, exp_tk});
  endtask

  function automatic logic [31:0] mk_pc(input int tag, input int set);
    return (tag << 9) | (set << 2);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd1234));
    n_tests = 0; n_fail = 0;
    for (int i = 0; i < HTE; i++) m_ctr[i] = 1;
    for (int s = 0; s < SETS; s++) begin
      m_v[s][0] = 1'b0; m_v[s][1] = 1'b0; m_lru[s] = 1'b0;
    end
    rst_n = 1'b0; f_pc = '0; d_valid = 0; d_pc = '0; d_kind = '0; d_resolved = 0;
    d_resolved_taken = 0; d_fetch_hit = 0; u_valid = 0; u_kind = '0; u_pc = '0;
    u_taken = 0; u_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty cache, weakly not-taken counters
    probe_f(mk_pc(1, 3), 1'b0, "R1 reset miss");
    probe_d(mk_pc(1, 3), 1'b0, "R1 reset counter not-taken");

    // R2: unconditional PC-relative insert
    upd(2'b01, mk_pc(4, 10), 1'b1, 32'h0000_4400);
    probe_f(mk_pc(4, 10), 1'b1, "R2 insert hit");
    check(f_target == 32'h0000_4400, "R2 target value", f_target, 32'h0000_4400);

    // R12: unconditional update leaves counter at weakly not-taken
    probe_d(mk_pc(4, 10), 1'b0, "R12 counter untouched");

    // R4: register-target conditional trains counter but is not cached
    upd(2'b10, mk_pc(5, 11), 1'b1, 32'h0000_1234);
    probe_f(mk_pc(5, 11), 1'b0, "R4 reg branch not cached");
    probe_d(mk_pc(5, 11), 1'b1, "R5 counter trained by reg cond");
    upd(2'b11, mk_pc(6, 12), 1'b1, 32'h0000_5678);
    probe_f(mk_pc(6, 12), 1'b0, "R4 uncond reg not cached");

    // R5 / R6: conditional PC-relative train up then down
    upd(2'b00, mk_pc(7, 20), 1'b1, 32'h0000_7000);
    probe_f(mk_pc(7, 20), 1'b1, "R5 taken inserts");
    upd(2'b00, mk_pc(7, 20), 1'b1, 32'h0000_7000);
    upd(2'b00, mk_pc(7, 20), 1'b1, 32'h0000_7000);
    upd(2'b00, mk_pc(7, 20), 1'b0, 32'h0000_7000);
    probe_f(mk_pc(7, 20), 1'b1, "R5 saturated stays cached");
    upd(2'b00, mk_pc(7, 20), 1'b0, 32'h0000_7000);
    probe_f(mk_pc(7, 20), 1'b0, "R6 drop below 2 invalidates");

    // R3: three branches in one set
    upd(2'b01, mk_pc(1, 40), 1'b1, 32'hA);
    upd(2'b01, mk_pc(2, 40), 1'b1, 32'hB);
    upd(2'b01, mk_pc(3, 40), 1'b1, 32'hC);
    probe_f(mk_pc(1, 40), 1'b0, "R3 oldest evicted");
    probe_f(mk_pc(2, 40), 1'b1, "R3 second kept");
    probe_f(mk_pc(3, 40), 1'b1, "R3 newest kept");

    // R11: aliasing 8192 bytes apart
    upd(2'b10, 32'h0000_0104, 1'b1, 32'h0);
    probe_d(32'h0000_2104, 1'b1, "R11 alias shares counter");

    // R7 / R8 / R10 precedence against a not-taken counter
    step(32'h0, 1'b1, 32'h0000_0300, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);
    step(32'h0, 1'b1, 32'h0000_0300, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);
    step(32'h0, 1'b1, 32'h0000_0300, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);
    step(32'h0, 1'b0, 32'h0000_0300, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0, 1'b0, 32'h0);

    // random mix over a conflicting address pool
    pool[0] = mk_pc(1, 5);  pool[1] = mk_pc(2, 5);  pool[2] = mk_pc(3, 5);
    pool[3] = mk_pc(1, 6);  pool[4] = mk_pc(9, 6);  pool[5] = mk_pc(1, 6) + 32'h2000;
    pool[6] = mk_pc(4, 7);  pool[7] = mk_pc(5, 7);
    for (int n = 0; n < 4000; n++) begin
      step(pool[$urandom % 8], 1'($urandom), pool[$urandom % 8], 2'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), pool[$urandom % 8], 1'($urandom),
           {16'h0, 16'($urandom)} & 32'hFFFF_FFFC);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule